// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port with Peripheral Override Pairs

This block controls a group of general-purpose I/O pins. Each pin has a direction bit and an output bit, and software writes both through plain write strobes. A chip-wide pull-up disable input can switch off every default pull-up at once. From these the block computes four pad controls for each pin: driver enable, driven value, pull-up enable and input-buffer enable. The pad input is gated by the input-buffer enable. It then crosses into the clock domain through a two-flop synchronizer, and the result can be read back as the pin register.

Peripheral modules can take over any pad control without touching the registers. Every control has its own enable/value pair, and each pair arrives as one bit per pin. The gated pad input is also offered to peripherals before the synchronizer, so a peripheral can run its own synchronizer or use the pin as a clock. All control and status pins are plain levels. The block has no streaming data interface, so no valid/ready handshake and no back-pressure apply.

Top module: `gpio_ovr_port`

## Requirements
- R1: During reset and right after it, the direction, output and pin registers read 0. With all override enables at 0, every pin then has its driver and its pull-up switched off.
- R2: A direction write strobe loads the direction register from its data bus on the next rising edge. An output write strobe does the same for the output register, independently of the other register. A register whose strobe is low keeps its value.
- R3: While a pin's pull-up override enable is 0, its pull-up is on exactly when its direction bit is 0, its output bit is 1 and the global pull-up disable is 0.
- R4: While a pin's pull-up override enable is 1, its pull-up equals its pull-up override value, whatever the direction, output and global disable bits are.
- R5: A pin's driver enable equals its direction bit while its driver override enable is 0. It equals the driver override value while that enable is 1.
- R6: While the driver is on, the driven value equals the value override when the value override enable is 1, and the output bit otherwise. While the driver is off, the driven value is 0.
- R7: A pin's input enable equals NOT sleep while its input override enable is 0. It equals the input override value while that enable is 1.
- R8: The raw digital input offered to peripherals equals the pad input while input enable is 1, and 0 while it is 0, in the same cycle with no register in the path.
- R9: The pin register shows the raw digital input as it was two rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_wr_en | input | 1 | Write strobe for the direction register |
| dir_wr_data | input | 8 | New direction bits (1 = drive) |
| out_wr_en | input | 1 | Write strobe for the output register |
| out_wr_data | input | 8 | New output bits |
| dir_rd | output | 8 | Direction register contents |
| out_rd | output | 8 | Output register contents |
| pin_rd | output | 8 | Synchronized pin register |
| pud_global | input | 1 | Global pull-up disable |
| sleep | input | 1 | Controller asleep; removes default input enable |
| pu_ovr_en | input | 8 | Per-pin pull-up override enable |
| pu_ovr_val | input | 8 | Per-pin pull-up override value |
| oe_ovr_en | input | 8 | Per-pin driver-enable override enable |
| oe_ovr_val | input | 8 | Per-pin driver-enable override value |
| pv_ovr_en | input | 8 | Per-pin driven-value override enable |
| pv_ovr_val | input | 8 | Per-pin driven-value override value |
| ie_ovr_en | input | 8 | Per-pin input-enable override enable |
| ie_ovr_val | input | 8 | Per-pin input-enable override value |
| pad_in | input | 8 | Level seen at the pads |
| pad_oe | output | 8 | Pad driver enable |
| pad_out | output | 8 | Pad driven value |
| pad_pu | output | 8 | Pad pull-up enable |
| pad_ie | output | 8 | Pad input-buffer enable |
| raw_in | output | 8 | Gated, unsynchronized input for peripherals |

## Verification
The assertions check on every cycle the selection rule of each pad control, the zeroing of gated inputs, the load and hold behaviour of both registers, and the stage-by-stage delay of the synchronizer. Only the bench's scenarios can show the end-to-end results. These are the reset contents seen at the ports, the two-edge latency from a pad change to the pin register, the independence of the two write strobes, and the interplay of sleep, global pull-up disable and mixed per-pin overrides. The bench drives random override patterns, mixed with directed all-on, all-off and sleep cases.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int unsigned GPIO_PINS = 8;
  localparam int unsigned GPIO_SYNC = 2;

  typedef struct packed {
    logic en;
    logic val;
  } ovr_pair_t;

  function automatic logic pick(input ovr_pair_t p, input logic dflt);
    return p.en ? p.val : dflt;
  endfunction
endpackage

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wr_data;
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wr_data));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] out_q,
  input  logic         pud_global,
  input  logic         sleep,
  input  logic [W-1:0] pu_ovr_en,
  input  logic [W-1:0] pu_ovr_val,
  input  logic [W-1:0] oe_ovr_en,
  input  logic [W-1:0] oe_ovr_val,
  input  logic [W-1:0] pv_ovr_en,
  input  logic [W-1:0] pv_ovr_val,
  input  logic [W-1:0] ie_ovr_en,
  input  logic [W-1:0] ie_ovr_val,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] pad_ie
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    ovr_pair_t pu_p, oe_p, pv_p, ie_p;
    logic      pu_dflt;

    always_comb begin
      pu_p    = '{en: pu_ovr_en[i], val: pu_ovr_val[i]};
      oe_p    = '{en: oe_ovr_en[i], val: oe_ovr_val[i]};
      pv_p    = '{en: pv_ovr_en[i], val: pv_ovr_val[i]};
      ie_p    = '{en: ie_ovr_en[i], val: ie_ovr_val[i]};
      pu_dflt = !dir_q[i] && out_q[i] && !pud_global;
      pad_pu[i]  = pick(pu_p, pu_dflt);
      pad_oe[i]  = pick(oe_p, dir_q[i]);
      pad_out[i] = pad_oe[i] && pick(pv_p, out_q[i]);
      pad_ie[i]  = pick(ie_p, !sleep);
    end

    assert_pu_dflt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pu_ovr_en[i] && dir_q[i] |-> !pad_pu[i]);
    assert_pu_pud_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !pu_ovr_en[i] && pud_global |-> !pad_pu[i]);
    assert_pu_ovr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pu_ovr_en[i] |-> pad_pu[i] == pu_ovr_val[i]);
    assert_oe_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[i] == (oe_ovr_en[i] ? oe_ovr_val[i] : dir_q[i]));
    assert_off_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pad_oe[i] |-> !pad_out[i]);
    assert_pv_ovr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[i] && pv_ovr_en[i] |-> pad_out[i] == pv_ovr_val[i]);
    assert_ie_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_ovr_en[i] |-> pad_ie[i] == !sleep);
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] ie,
  output logic [W-1:0] raw,
  output logic [W-1:0] pin_q
);
  logic [W-1:0] stg [STAGES];
  logic         live;

  assign raw   = pad_in & ie;
  assign pin_q = stg[STAGES-1];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= raw;
      end
      assert_stage0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> stg[0] == $past(raw));
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[k] <= '0;
        else        stg[k] <= stg[k-1];
      end
      assert_stage_R9: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> stg[k] == $past(stg[k-1]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (raw & ~ie) == '0);
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned PINS = GPIO_PINS,
  parameter int unsigned SYNC = GPIO_SYNC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dir_wr_en,
  input  logic [PINS-1:0] dir_wr_data,
  input  logic            out_wr_en,
  input  logic [PINS-1:0] out_wr_data,
  output logic [PINS-1:0] dir_rd,
  output logic [PINS-1:0] out_rd,
  output logic [PINS-1:0] pin_rd,
  input  logic            pud_global,
  input  logic            sleep,
  input  logic [PINS-1:0] pu_ovr_en,
  input  logic [PINS-1:0] pu_ovr_val,
  input  logic [PINS-1:0] oe_ovr_en,
  input  logic [PINS-1:0] oe_ovr_val,
  input  logic [PINS-1:0] pv_ovr_en,
  input  logic [PINS-1:0] pv_ovr_val,
  input  logic [PINS-1:0] ie_ovr_en,
  input  logic [PINS-1:0] ie_ovr_val,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_oe,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_pu,
  output logic [PINS-1:0] pad_ie,
  output logic [PINS-1:0] raw_in
);
  logic [PINS-1:0] dir_q, out_q;

  gpio_reg_bank #(.W(PINS)) u_dir (
    .clk(clk), .rst_n(rst_n), .wr_en(dir_wr_en), .wr_data(dir_wr_data), .q(dir_q));

  gpio_reg_bank #(.W(PINS)) u_out (
    .clk(clk), .rst_n(rst_n), .wr_en(out_wr_en), .wr_data(out_wr_data), .q(out_q));

  gpio_pad_mux #(.W(PINS)) u_mux (
    .clk(clk), .rst_n(rst_n), .dir_q(dir_q), .out_q(out_q),
    .pud_global(pud_global), .sleep(sleep),
    .pu_ovr_en(pu_ovr_en), .pu_ovr_val(pu_ovr_val),
    .oe_ovr_en(oe_ovr_en), .oe_ovr_val(oe_ovr_val),
    .pv_ovr_en(pv_ovr_en), .pv_ovr_val(pv_ovr_val),
    .ie_ovr_en(ie_ovr_en), .ie_ovr_val(ie_ovr_val),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_ie(pad_ie));

  gpio_in_sync #(.W(PINS), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .ie(pad_ie),
    .raw(raw_in), .pin_q(pin_rd));

  assign dir_rd = dir_q;
  assign out_rd = out_q;

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (dir_rd == '0 && out_rd == '0 && pin_rd == '0));
endmodule

// File: tb/test_gpio_ovr_port.sv
`timescale 1ns/1ps
module test_gpio_ovr_port;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_wr_en = 0, out_wr_en = 0, pud_global = 0, sleep = 0;
  logic [W-1:0] dir_wr_data = '0, out_wr_data = '0, pad_in = '0;
  logic [W-1:0] pu_ovr_en = '0, pu_ovr_val = '0, oe_ovr_en = '0, oe_ovr_val = '0;
  logic [W-1:0] pv_ovr_en = '0, pv_ovr_val = '0, ie_ovr_en = '0, ie_ovr_val = '0;
  logic [W-1:0] dir_rd, out_rd, pin_rd, pad_oe, pad_out, pad_pu, pad_ie, raw_in;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [W-1:0] m_dir = '0, m_out = '0, m_s1 = '0, m_s2 = '0;

  always #2.5 clk = ~clk;

  gpio_ovr_port i_gpio_ovr_port (
    .clk, .rst_n, .dir_wr_en, .dir_wr_data, .out_wr_en, .out_wr_data,
    .dir_rd, .out_rd, .pin_rd, .pud_global, .sleep,
    .pu_ovr_en, .pu_ovr_val, .oe_ovr_en, .oe_ovr_val,
    .pv_ovr_en, .pv_ovr_val, .ie_ovr_en, .ie_ovr_val,
    .pad_in, .pad_oe, .pad_out, .pad_pu, .pad_ie, .raw_in);

  function automatic logic [W-1:0] f_oe();
    return (oe_ovr_en & oe_ovr_val) | (~oe_ovr_en & m_dir);
  endfunction
  function automatic logic [W-1:0] f_pu();
    logic [W-1:0] d = ~m_dir & m_out & {W{~pud_global}};
    return (pu_ovr_en & pu_ovr_val) | (~pu_ovr_en & d);
  endfunction
  function automatic logic [W-1:0] f_out();
    logic [W-1:0] v = (pv_ovr_en & pv_ovr_val) | (~pv_ovr_en & m_out);
    return v & f_oe();
  endfunction
  function automatic logic [W-1:0] f_ie();
    return (ie_ovr_en & ie_ovr_val) | (~ie_ovr_en & {W{~sleep}});
  endfunction
  function automatic logic [W-1:0] f_raw();
    return pad_in & f_ie();
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      m_s2 = m_s1;
      m_s1 = f_raw();
      if (dir_wr_en) m_dir = dir_wr_data;
      if (out_wr_en) m_out = out_wr_data;
    end
  end

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2", "dir_rd", dir_rd, m_dir);
    chk("R2", "out_rd", out_rd, m_out);
    chk("R5", "pad_oe", pad_oe, f_oe());
    chk("R6", "pad_out", pad_out, f_out());
    chk("R3/R4", "pad_pu", pad_pu, f_pu());
    chk("R7", "pad_ie", pad_ie, f_ie());
    chk("R8", "raw_in", raw_in, f_raw());
    chk("R9", "pin_rd", pin_rd, m_s2);
  endtask

  task automatic rand_ovr();
    pu_ovr_en = W'($urandom); pu_ovr_val = W'($urandom);
    oe_ovr_en = W'($urandom); oe_ovr_val = W'($urandom);
    pv_ovr_en = W'($urandom); pv_ovr_val = W'($urandom);
    ie_ovr_en = W'($urandom); ie_ovr_val = W'($urandom);
  endtask

  task automatic set_all_ovr(input logic [W-1:0] en, input logic [W-1:0] val);
    pu_ovr_en = en; oe_ovr_en = en; pv_ovr_en = en; ie_ovr_en = en;
    pu_ovr_val = val; oe_ovr_val = val; pv_ovr_val = val; ie_ovr_val = val;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    pad_in = 8'hff;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset contents and pad state with no overrides
    chk("R1", "dir_rd reset", dir_rd, '0);
    chk("R1", "out_rd reset", out_rd, '0);
    chk("R1", "pin_rd reset", pin_rd, '0);
    chk("R1", "pad_oe reset", pad_oe, '0);
    chk("R1", "pad_pu reset", pad_pu, '0);
    @(negedge clk); rst_n = 1'b1;

    // R9: directed two-edge latency, pad change seen two edges later
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'ha5;
    @(negedge clk); #1; chk("R9", "pin after 1 edge", pin_rd, 8'h00);
    @(negedge clk); #1; chk("R9", "pin after 2 edges", pin_rd, 8'ha5);

    // R2: only the direction strobe
    dir_wr_en = 1; dir_wr_data = 8'h3c; out_wr_data = 8'hff;
    @(negedge clk); dir_wr_en = 0; #1;
    chk("R2", "dir loaded", dir_rd, 8'h3c);
    chk("R2", "out untouched", out_rd, 8'h00);
    out_wr_en = 1; out_wr_data = 8'hf0;
    @(negedge clk); out_wr_en = 0; #1;
    chk("R2", "out loaded", out_rd, 8'hf0);
    chk("R3", "default pull-up", pad_pu, 8'hc0);
    pud_global = 1; #1;
    chk("R3", "pud kills pull-up", pad_pu, 8'h00);
    set_all_ovr(8'hff, 8'hff); #1;
    chk("R4", "pu override wins over pud", pad_pu, 8'hff);
    pud_global = 0;
    set_all_ovr(8'hff, 8'h00); #1;
    chk("R5", "oe forced off", pad_oe, 8'h00);
    chk("R6", "out zero when off", pad_out, 8'h00);
    set_all_ovr(8'h00, 8'h00); sleep = 1; #1;
    chk("R7", "sleep disables input", pad_ie, 8'h00);
    chk("R8", "raw zero in sleep", raw_in, 8'h00);
    ie_ovr_en = 8'h0f; ie_ovr_val = 8'h05; #1;
    chk("R7", "ie override in sleep", pad_ie, 8'h05);
    chk("R8", "raw with ie override", raw_in, 8'ha5 & 8'h05);
    sleep = 0;

    for (int it = 0; it < 4000; it++) begin
      @(negedge clk);
      dir_wr_en = ($urandom % 4) == 0; dir_wr_data = W'($urandom);
      out_wr_en = ($urandom % 4) == 0; out_wr_data = W'($urandom);
      pad_in = W'($urandom);
      pud_global = ($urandom % 5) == 0;
      sleep = ($urandom % 6) == 0;
      case (it % 50)
        0: set_all_ovr(8'h00, 8'h00);
        1: set_all_ovr(8'hff, 8'hff);
        2: set_all_ovr(8'hff, 8'h00);
        default: rand_ovr();
      endcase
      #1; check_all();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule